// File: doc/BRIEF.md
# PRBS31 Bit Error Rate Tester

This block measures the bit error rate of a serial link with a 31-stage pseudo-random bit sequence. The transmit half steps a linear feedback shift register with the characteristic polynomial 1 + x^28 + x^31 once per enable pulse and presents the inverted feedback bit as the line bit. The receive half needs no seed agreed in advance. It builds its own copy of the register from the first 31 valid bits it sees, and from then on it predicts every later bit and compares it with the one received.

Two saturating counters hold the number of compared bits and the number of mismatches. An external processor reads them and forms the ratio itself. A synchronous clear zeroes both counters and sends the receiver back to its seeding phase, so a new measurement interval can start at any point in the stream.

Top module: `prbs31_bert`

## Requirements
- R1: After reset the transmit register holds the seed 31'h0000_0001. On each cycle with `tx_en` high, the feedback f = s[30] XOR s[27] is computed from the state s[30:0], `tx_bit` takes the value NOT f, `tx_vld` goes high, and the state becomes {s[29:0], f}. Both outputs are registered and appear after that clock edge.
- R2: A cycle with `tx_en` low sets `tx_vld` low and leaves `tx_bit` and the register unchanged, so the sequence resumes where it stopped.
- R3: The first 31 bits accepted with `rx_vld` high after reset or clear are inverted and shifted into the local register. They are not counted. `locked` goes high on the edge that takes the 31st bit.
- R4: While locked, each bit accepted with `rx_vld` high adds one to `bit_cnt` and moves the local generator on by one step. The local generator steps by its own feedback, independent of the received value.
- R5: While locked, a received bit that differs from the predicted bit (NOT of the local feedback) adds one to `err_cnt`. Each flipped bit in a burst counts exactly once.
- R6: `bit_cnt` and `err_cnt` are CNT_W bits wide (default 32). Each stops at its all-ones value instead of wrapping.
- R7: `clr` high at a clock edge zeroes both counters, drops `locked` and restarts seeding from the next valid bit.
- R8: Cycles with `rx_vld` low change neither the counters nor the lock state, whatever `rx_bit` does.
- R9: After reset `tx_vld`, `tx_bit`, `locked`, `bit_cnt` and `err_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Advance the transmit generator by one bit |
| tx_bit | output | 1 | Transmitted pattern bit |
| tx_vld | output | 1 | High for one cycle after each advance |
| rx_bit | input | 1 | Received bit |
| rx_vld | input | 1 | Strobe marking `rx_bit` as valid |
| clr | input | 1 | Synchronous clear of counters and lock |
| locked | output | 1 | Seeding complete, comparisons active |
| bit_cnt | output | CNT_W | Number of compared bits, saturating |
| err_cnt | output | CNT_W | Number of mismatched bits, saturating |

## Verification
The transmit output is checked bit by bit against an independent model of the polynomial from the reset seed, with idle gaps in the enable to show that the sequence resumes. The receiver is fed a stream that starts at an arbitrary phase of the sequence. A clean stream tells correct seeding apart from a wrong tap choice or a missing inversion. Isolated flips every seventh bit and a five-bit burst tell a free-running local generator apart from one fed by received bits, which would count more errors. A stream with every bit flipped, run with a narrow counter width, drives both counters to their ceiling. A clear followed by relocking at a new phase shows that the receiver seeds itself again.

// File: rtl/prbs_pkg.sv
// Package: shared constants and helpers for the PRBS31 tester.
// Assumes: register bit 0 is the newest bit shifted in.
package prbs_pkg;
    localparam int PRBS_W = 31;
    localparam int TAP_A  = 31;   // polynomial term x^31
    localparam int TAP_B  = 28;   // polynomial term x^28
    localparam int SEED_CNT_W = $clog2(PRBS_W + 1);

    typedef logic [PRBS_W-1:0] prbs_state_t;

    typedef enum logic {
        PH_SEED  = 1'b0,
        PH_TRACK = 1'b1
    } chk_phase_t;

    // Feedback bit of the 1 + x^28 + x^31 register
    function automatic logic prbs_fb(input prbs_state_t s);
        return s[TAP_A-1] ^ s[TAP_B-1];
    endfunction

    // Next register state for a given feedback bit
    function automatic prbs_state_t prbs_step(input prbs_state_t s, input logic fb);
        return {s[PRBS_W-2:0], fb};
    endfunction
endpackage

// File: rtl/prbs31_gen.sv
// Module: prbs31_gen
// Transmit-side generator. Each enable advances the register one step and
// registers the inverted feedback as the line bit.
// Assumes: SEED is nonzero, so the register never enters the all-zero state.
module prbs31_gen
    import prbs_pkg::*;
#(
    parameter prbs_state_t SEED = 31'h0000_0001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bit_o,
    output logic vld_o
);
    prbs_state_t state_q;
    logic        fb;

    // Feedback from the current register state
    always_comb fb = prbs_fb(state_q);

    // Advance the register and register the output bit on each enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
            bit_o   <= 1'b0;
            vld_o   <= 1'b0;
        end else begin
            vld_o <= en;
            if (en) begin
                state_q <= prbs_step(state_q, fb);
                bit_o   <= ~fb;
            end
        end
    end

    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !vld_o);                                   // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(bit_o));                           // R2
    AST_TX_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);                                    // R1
endmodule

// File: rtl/prbs31_chk.sv
// Module: prbs31_chk
// Receive-side checker. In the seed phase it shifts the inverted received
// bits into its register. After 31 bits it runs freely and flags each valid
// bit as compared and, on a mismatch, as an error.
// Assumes: the seed bits arrive without errors; an error there breaks the lock.
module prbs31_chk
    import prbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rx_bit,
    input  logic rx_vld,
    output logic cmp_vld,
    output logic cmp_err,
    output logic locked
);
    localparam logic [SEED_CNT_W-1:0] LAST_SEED = SEED_CNT_W'(PRBS_W - 1);

    chk_phase_t              phase_q;
    logic [SEED_CNT_W-1:0]   seed_cnt_q;
    prbs_state_t             state_q;
    logic                    fb;
    logic                    predicted;

    // Local prediction from the register state
    always_comb begin
        fb        = prbs_fb(state_q);
        predicted = ~fb;
    end

    // Comparison strobes for the counters
    always_comb begin
        cmp_vld = rx_vld && (phase_q == PH_TRACK);
        cmp_err = cmp_vld && (rx_bit != predicted);
    end

    assign locked = (phase_q == PH_TRACK);

    // Seed phase loads received bits, track phase free-runs
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q    <= PH_SEED;
            seed_cnt_q <= '0;
            state_q    <= '0;
        end else if (rx_vld) begin
            if (phase_q == PH_SEED) begin
                state_q    <= prbs_step(state_q, ~rx_bit);
                seed_cnt_q <= seed_cnt_q + 1'b1;
                if (seed_cnt_q == LAST_SEED)
                    phase_q <= PH_TRACK;
            end else begin
                state_q <= prbs_step(state_q, fb);
            end
        end
    end

    AST_LOCK_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(rx_vld));                  // R3
    AST_IDLE_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_vld && !clr) |=> $stable(locked));            // R8
    AST_ERR_IS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |-> cmp_vld);                              // R5
endmodule

// File: rtl/sat_counter.sv
// Module: sat_counter
// Up counter with synchronous clear that holds at all ones.
// Assumes: clear takes priority over increment.
module sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Count up on inc, stop at TOP, zero on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (inc && q != TOP)
            q <= q + 1'b1;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q == TOP && !clr) |=> q == TOP);                  // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (q == $past(q)) || (q == $past(q) + 1'b1)); // R4
endmodule

// File: rtl/prbs31_bert.sv
// Module: prbs31_bert
// Top level: transmit generator, receive checker and the two saturating
// counters of compared and mismatched bits.
// Assumes: the processor reading the counters forms the ratio itself.
module prbs31_bert
    import prbs_pkg::*;
#(
    parameter int          CNT_W   = 32,
    parameter prbs_state_t TX_SEED = 31'h0000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    output logic             tx_bit,
    output logic             tx_vld,
    input  logic             rx_bit,
    input  logic             rx_vld,
    input  logic             clr,
    output logic             locked,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [CNT_W-1:0] err_cnt
);
    logic cmp_vld;
    logic cmp_err;

    prbs31_gen #(.SEED(TX_SEED)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tx_en),
        .bit_o (tx_bit),
        .vld_o (tx_vld)
    );

    prbs31_chk u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .rx_bit  (rx_bit),
        .rx_vld  (rx_vld),
        .cmp_vld (cmp_vld),
        .cmp_err (cmp_err),
        .locked  (locked)
    );

    sat_counter #(.W(CNT_W)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (cmp_vld),
        .q     (bit_cnt)
    );

    sat_counter #(.W(CNT_W)) u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (cmp_err),
        .q     (err_cnt)
    );

    AST_UNLOCKED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !clr) |=> $stable(bit_cnt));           // R3
    AST_ERR_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= bit_cnt);                               // R5
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bit_cnt == '0) && (err_cnt == '0) && !locked); // R7
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_vld && !clr) |=> $stable(bit_cnt) && $stable(err_cnt)); // R8
endmodule

// File: tb/test_prbs31_bert.sv
module test_prbs31_bert;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0;
    logic          tx_bit, tx_vld;
    logic          rx_bit = 1'b0;
    logic          rx_vld = 1'b0;
    logic          clr = 1'b0;
    logic          locked;
    logic [CW-1:0] bit_cnt, err_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_bits = 0;
    int exp_errs = 0;
    logic [30:0] tx_model = 31'h0000_0001;
    logic [30:0] rx_model = 31'h2B3C_4D5E;

    always #2.5 clk = ~clk;

    prbs31_bert #(.CNT_W(CW)) i_prbs31_bert (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit), .tx_vld(tx_vld),
        .rx_bit(rx_bit), .rx_vld(rx_vld), .clr(clr), .locked(locked),
        .bit_cnt(bit_cnt), .err_cnt(err_cnt)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
    endfunction

    // Next bit of the reference receive stream
    function automatic logic rx_next();
        logic f;
        f = rx_model[30] ^ rx_model[27];
        rx_model = {rx_model[29:0], f};
        return ~f;
    endfunction

    // mode: 0 clean, 1 flip every 7th, 2 flip all, 3 flip first five
    task automatic send_stream(input int n, input int mode, input bit counted);
        for (int i = 0; i < n; i++) begin
            logic b;
            logic flip;
            b = rx_next();
            flip = (mode == 1 && (i % 7) == 6) || (mode == 2) || (mode == 3 && i < 5);
            @(negedge clk);
            rx_bit = b ^ flip;
            rx_vld = 1'b1;
            if (counted) begin
                exp_bits++;
                if (flip) exp_errs++;
            end
        end
        @(negedge clk);
        rx_vld = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 tx_vld", tx_vld, 0);
        check("R9 tx_bit", tx_bit, 0);
        check("R9 locked", locked, 0);
        check("R9 bit_cnt", bit_cnt, 0);
        check("R9 err_cnt", err_cnt, 0);
    endtask

    task automatic t_tx();
        int bad = 0;
        for (int i = 0; i < 80; i++) begin
            logic f;
            @(negedge clk);
            tx_en = (i % 9) != 4;
            if (tx_en) begin
                f = tx_model[30] ^ tx_model[27];
                tx_model = {tx_model[29:0], f};
            end
            @(negedge clk);
            tx_en = 1'b0;
            if (i % 9 != 4) begin
                if (tx_bit !== ~f || tx_vld !== 1'b1) bad++;
            end else begin
                check("R2 idle tx_vld", tx_vld, 0);
            end
        end
        check("R1 sequence mismatches", bad, 0);
        @(negedge clk);
        check("R2 tx_vld low after idle", tx_vld, 0);
    endtask

    task automatic t_seed();
        send_stream(30, 0, 0);
        check("R3 not locked after 30", locked, 0);
        check("R3 no count in seed", bit_cnt, 0);
        send_stream(1, 0, 0);
        check("R3 locked after 31", locked, 1);
        check("R3 count zero at lock", bit_cnt, 0);
    endtask

    task automatic t_clean();
        send_stream(50, 0, 1);
        check("R4 bit_cnt clean", bit_cnt, exp_bits);
        check("R4 err_cnt clean", err_cnt, exp_errs);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_bit = i[0];
            rx_vld = 1'b0;
        end
        @(negedge clk);
        check("R8 bit_cnt idle", bit_cnt, exp_bits);
        check("R8 err_cnt idle", err_cnt, exp_errs);
        check("R8 locked idle", locked, 1);
    endtask

    task automatic t_errors();
        send_stream(70, 1, 1);
        check("R5 sparse errors", err_cnt, exp_errs);
        send_stream(20, 3, 1);
        check("R5 burst counted once each", err_cnt, exp_errs);
        check("R4 bits after errors", bit_cnt, exp_bits);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_bits = 0;
        exp_errs = 0;
        check("R7 bit_cnt cleared", bit_cnt, 0);
        check("R7 err_cnt cleared", err_cnt, 0);
        check("R7 unlocked", locked, 0);
        repeat (13) void'(rx_next());
        send_stream(31, 0, 0);
        check("R7 relocked", locked, 1);
        send_stream(20, 0, 1);
        check("R7 clean after relock", err_cnt, 0);
        check("R7 bits after relock", bit_cnt, exp_bits);
    endtask

    task automatic t_sat();
        send_stream(300, 2, 1);
        check("R6 bit_cnt saturates", bit_cnt, sat(exp_bits));
        check("R6 err_cnt saturates", err_cnt, sat(exp_errs));
        send_stream(10, 2, 1);
        check("R6 bit_cnt holds", bit_cnt, (1 << CW) - 1);
        check("R6 err_cnt holds", err_cnt, (1 << CW) - 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_tx();
        t_seed();
        t_clean();
        t_idle();
        t_errors();
        t_clear();
        t_sat();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule